// File: doc/BRIEF.md
# Probe Trigger Match Unit

This block watches one probe bus and raises a one-bit match flag each clock when the probe satisfies a condition that is programmed while the chip is running. Each probe bit carries its own 3-bit code: the bit must be low, must be high, is ignored, must have risen, fallen, changed in either direction, or stayed the same since the previous sample. A global operator then either requires every bit condition to hold, requires the combined result to fail, or replaces the bit conditions by an unsigned magnitude comparison of the whole probe against a constant.

The block keeps a registered copy of the previous probe sample for the edge conditions and registers its result, so the flag trails the sample it describes by one clock. The operator and the code vector are written together through a load strobe. Several such units can be placed on one probe and their flags combined elsewhere. The probe width is a parameter.

Top module: `trig_match_unit`

## Requirements
- R1: While `rst_n` is low, `match_o` is 0 and the stored previous sample is cleared.
- R2: A configuration write (`cfg_load_i` high at a rising edge) governs the probe sample taken at the next rising edge; the sample taken at the write edge itself is judged by the old configuration, and `cfg_op_i`/`cfg_code_i` have no effect while `cfg_load_i` is low.
- R3: With operator EQ (code 0) the flag is 1 when every bit meets its level code; bit code field i sits at `cfg_code_i[3i+2:3i]`, code 0 needs the bit low, code 1 needs it high, code 2 accepts any value.
- R4: With operator NE (code 1) the flag is the inverse of the combined per-bit result that EQ would give, edge codes included.
- R5: Edge codes compare each bit with the sample one clock earlier: code 3 needs 0 then 1, code 4 needs 1 then 0, code 5 needs any change, code 6 needs no change.
- R6: On the first sample after reset is released no edge code (3 to 6) is satisfied.
- R7: Operators GT (2), LT (3), GE (4) and LE (5) compare the probe as an unsigned number with a constant whose bit i is 1 exactly where the bit code is 1; every other code, don't-care and edge codes included, contributes a 0 bit.
- R8: Operator codes 6 and 7 disable the unit (flag 0), and bit code 7 is a condition that never holds.
- R9: Configuration is not cleared by reset and may be written while reset is asserted.
- R10: `match_o` describes the probe sample taken at the previous rising edge: one clock of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| probe_i | input | PROBE_W | Observed bus |
| cfg_load_i | input | 1 | Writes operator and code vector at this edge |
| cfg_op_i | input | 3 | Operator: 0 EQ, 1 NE, 2 GT, 3 LT, 4 GE, 5 LE, 6/7 off |
| cfg_code_i | input | 3*PROBE_W | Per-bit codes, bit i at [3i+2:3i] |
| match_o | output | 1 | Registered match flag |

## Verification
The configuration write and the evaluation of a sample fall on the same clock edge, and the design must judge that sample with the old settings while the following one sees the new settings. The bench provokes this by writing a new operator in the very cycle a probe value that separates the two settings is presented, and its scoreboard model applies the write only after it has computed the expectation for that sample. The release of reset also coincides with the first edge evaluation; the bench programs edge codes during reset and checks that the first sample afterwards does not match while the second one can.

// File: rtl/tmu_pkg.sv
`timescale 1ns/1ps
package tmu_pkg;
  localparam int CODE_W = 3;

  typedef enum logic [2:0] {
    OP_EQ   = 3'd0,
    OP_NE   = 3'd1,
    OP_GT   = 3'd2,
    OP_LT   = 3'd3,
    OP_GE   = 3'd4,
    OP_LE   = 3'd5,
    OP_OFFA = 3'd6,
    OP_OFFB = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    BC_ZERO  = 3'd0,
    BC_ONE   = 3'd1,
    BC_ANY   = 3'd2,
    BC_RISE  = 3'd3,
    BC_FALL  = 3'd4,
    BC_BOTH  = 3'd5,
    BC_STILL = 3'd6,
    BC_NEVER = 3'd7
  } bitc_e;
endpackage

// File: rtl/tmu_cfg_store.sv
`timescale 1ns/1ps
module tmu_cfg_store #(
  parameter int PROBE_W = 8
) (
  input  logic                                clk,
  input  logic                                cfg_load_i,
  input  logic [2:0]                          cfg_op_i,
  input  logic [tmu_pkg::CODE_W*PROBE_W-1:0]  cfg_code_i,
  output logic [2:0]                          op_q,
  output logic [tmu_pkg::CODE_W*PROBE_W-1:0]  code_q
);
  localparam int VEC_W = tmu_pkg::CODE_W * PROBE_W;

  logic [2:0]       op_d;
  logic [VEC_W-1:0] code_d;

  always_comb begin
    op_d   = op_q;
    code_d = code_q;
    if (cfg_load_i) begin
      op_d   = cfg_op_i;
      code_d = cfg_code_i;
    end
  end

  // Settings survive reset on purpose: no reset term here.
  always_ff @(posedge clk) begin
    op_q   <= op_d;
    code_q <= code_d;
  end
endmodule

// File: rtl/tmu_history.sv
`timescale 1ns/1ps
module tmu_history #(
  parameter int PROBE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PROBE_W-1:0] probe_i,
  output logic [PROBE_W-1:0] prev_q,
  output logic               pv_q
);
  logic [PROBE_W-1:0] prev_d;
  logic               pv_d;

  always_comb begin
    prev_d = probe_i;
    pv_d   = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pv_q   <= 1'b0;
    end else begin
      prev_q <= prev_d;
      pv_q   <= pv_d;
    end
  end
endmodule

// File: rtl/tmu_bit_eval.sv
`timescale 1ns/1ps
module tmu_bit_eval #(
  parameter int PROBE_W = 8
) (
  input  logic [PROBE_W-1:0]                  cur_i,
  input  logic [PROBE_W-1:0]                  prev_i,
  input  logic                                pv_i,
  input  logic [tmu_pkg::CODE_W*PROBE_W-1:0]  code_i,
  output logic                                all_hit_o,
  output logic [PROBE_W-1:0]                  operand_o
);
  import tmu_pkg::*;

  logic [PROBE_W-1:0] hit;

  for (genvar i = 0; i < PROBE_W; i++) begin : g_bit
    logic [CODE_W-1:0] c;
    logic              h;
    logic              cb;
    logic              pb;

    assign c  = code_i[i*CODE_W +: CODE_W];
    assign cb = cur_i[i];
    assign pb = prev_i[i];

    always_comb begin
      h = 1'b0;
      case (c)
        BC_ZERO:  h = ~cb;
        BC_ONE:   h = cb;
        BC_ANY:   h = 1'b1;
        BC_RISE:  h = pv_i & ~pb & cb;
        BC_FALL:  h = pv_i & pb & ~cb;
        BC_BOTH:  h = pv_i & (pb ^ cb);
        BC_STILL: h = pv_i & ~(pb ^ cb);
        default:  h = 1'b0;
      endcase
    end

    assign hit[i]       = h;
    assign operand_o[i] = (c == BC_ONE);
  end

  assign all_hit_o = &hit;
endmodule

// File: rtl/tmu_mag_eval.sv
`timescale 1ns/1ps
module tmu_mag_eval #(
  parameter int PROBE_W = 8
) (
  input  logic [PROBE_W-1:0] a_i,
  input  logic [PROBE_W-1:0] b_i,
  output logic               gt_o,
  output logic               eq_o,
  output logic               lt_o
);
  localparam int EXT_W = PROBE_W + 1;

  logic [EXT_W-1:0] a_minus_b;
  logic [EXT_W-1:0] b_minus_a;

  assign a_minus_b = {1'b0, a_i} - {1'b0, b_i};
  assign b_minus_a = {1'b0, b_i} - {1'b0, a_i};

  assign lt_o = a_minus_b[PROBE_W];
  assign gt_o = b_minus_a[PROBE_W];
  assign eq_o = ~|a_minus_b;
endmodule

// File: rtl/trig_match_unit.sv
`timescale 1ns/1ps
module trig_match_unit #(
  parameter int PROBE_W = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [PROBE_W-1:0]                  probe_i,
  input  logic                                cfg_load_i,
  input  logic [2:0]                          cfg_op_i,
  input  logic [tmu_pkg::CODE_W*PROBE_W-1:0]  cfg_code_i,
  output logic                                match_o
);
  import tmu_pkg::*;

  localparam int VEC_W = CODE_W * PROBE_W;

  logic [2:0]         op_q;
  logic [VEC_W-1:0]   code_q;
  logic [PROBE_W-1:0] prev_q;
  logic               pv_q;
  logic               all_hit;
  logic [PROBE_W-1:0] operand;
  logic               mag_gt;
  logic               mag_eq;
  logic               mag_lt;
  logic               match_d;
  logic               match_q;

  tmu_cfg_store #(.PROBE_W(PROBE_W)) u_cfg (
    .clk        (clk),
    .cfg_load_i (cfg_load_i),
    .cfg_op_i   (cfg_op_i),
    .cfg_code_i (cfg_code_i),
    .op_q       (op_q),
    .code_q     (code_q)
  );

  tmu_history #(.PROBE_W(PROBE_W)) u_hist (
    .clk     (clk),
    .rst_n   (rst_n),
    .probe_i (probe_i),
    .prev_q  (prev_q),
    .pv_q    (pv_q)
  );

  tmu_bit_eval #(.PROBE_W(PROBE_W)) u_bits (
    .cur_i     (probe_i),
    .prev_i    (prev_q),
    .pv_i      (pv_q),
    .code_i    (code_q),
    .all_hit_o (all_hit),
    .operand_o (operand)
  );

  tmu_mag_eval #(.PROBE_W(PROBE_W)) u_mag (
    .a_i  (probe_i),
    .b_i  (operand),
    .gt_o (mag_gt),
    .eq_o (mag_eq),
    .lt_o (mag_lt)
  );

  always_comb begin
    match_d = 1'b0;
    case (op_q)
      OP_EQ:   match_d = all_hit;
      OP_NE:   match_d = ~all_hit;
      OP_GT:   match_d = mag_gt;
      OP_LT:   match_d = mag_lt;
      OP_GE:   match_d = mag_gt | mag_eq;
      OP_LE:   match_d = mag_lt | mag_eq;
      default: match_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= match_d;
  end

  assign match_o = match_q;
endmodule

// File: rtl/tmu_checker.sv
`timescale 1ns/1ps
module tmu_checker #(
  parameter int PROBE_W = 8
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic                                cfg_load_i,
  input logic [2:0]                          op_q,
  input logic [tmu_pkg::CODE_W*PROBE_W-1:0]  code_q,
  input logic                                pv_q,
  input logic                                mag_gt,
  input logic                                mag_eq,
  input logic                                mag_lt,
  input logic                                match_o
);
  import tmu_pkg::*;

  logic any_edge;
  logic all_any;

  always_comb begin
    any_edge = 1'b0;
    all_any  = 1'b1;
    for (int i = 0; i < PROBE_W; i++) begin
      if (code_q[i*CODE_W +: CODE_W] inside {BC_RISE, BC_FALL, BC_BOTH, BC_STILL})
        any_edge = 1'b1;
      if (code_q[i*CODE_W +: CODE_W] != BC_ANY)
        all_any = 1'b0;
    end
  end

  AST_RESET_LOW: assert property (@(posedge clk) !rst_n |-> !match_o); // R1

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load_i |=> ($stable(op_q) && $stable(code_q))); // R2

  AST_ALL_ANY_EQ: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_EQ && all_any) |=> match_o); // R3

  AST_FIRST_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!pv_q && op_q == OP_EQ && any_edge) |=> !match_o); // R6

  AST_MAG_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({mag_gt, mag_eq, mag_lt}) == 1); // R7

  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_OFFA || op_q == OP_OFFB) |=> !match_o); // R8
endmodule

bind trig_match_unit tmu_checker #(.PROBE_W(PROBE_W)) u_tmu_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_load_i (cfg_load_i),
  .op_q       (op_q),
  .code_q     (code_q),
  .pv_q       (pv_q),
  .mag_gt     (mag_gt),
  .mag_eq     (mag_eq),
  .mag_lt     (mag_lt),
  .match_o    (match_o)
);

// File: tb/trig_match_unit_bench.sv
`timescale 1ns/1ps
module trig_match_unit_bench;
  localparam int W = 8;
  localparam int CW = 3 * W;

  logic          clk;
  logic          rst_n;
  logic [W-1:0]  probe_i;
  logic          cfg_load_i;
  logic [2:0]    cfg_op_i;
  logic [CW-1:0] cfg_code_i;
  logic          match_o;

  trig_match_unit #(.PROBE_W(W)) u_trig_match_unit (
    .clk(clk), .rst_n(rst_n), .probe_i(probe_i), .cfg_load_i(cfg_load_i),
    .cfg_op_i(cfg_op_i), .cfg_code_i(cfg_code_i), .match_o(match_o)
  );

  typedef struct {
    bit    exp;
    string tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench-side model state
  logic [W-1:0]  m_prev = '0;
  bit            m_pv = 0;
  logic [2:0]    m_op = 3'd7;
  logic [CW-1:0] m_cd = '0;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [CW-1:0] mk(input string s);
    logic [CW-1:0] r = '0;
    for (int i = 0; i < W; i++) begin
      logic [2:0] c;
      case (s[W-1-i])
        "0": c = 3'd0;
        "1": c = 3'd1;
        "X": c = 3'd2;
        "R": c = 3'd3;
        "F": c = 3'd4;
        "B": c = 3'd5;
        "N": c = 3'd6;
        default: c = 3'd7;
      endcase
      r[i*3 +: 3] = c;
    end
    return r;
  endfunction

  function automatic bit model(input logic [W-1:0] cur, input logic [W-1:0] prv,
                               input bit pv, input logic [2:0] op, input logic [CW-1:0] cd);
    bit ok = 1;
    logic [W-1:0] k = '0;
    for (int i = 0; i < W; i++) begin
      bit h;
      unique case (cd[i*3 +: 3])
        3'd0: h = (cur[i] == 1'b0);
        3'd1: begin h = (cur[i] == 1'b1); k[i] = 1'b1; end
        3'd2: h = 1;
        3'd3: h = pv && prv[i] == 1'b0 && cur[i] == 1'b1;
        3'd4: h = pv && prv[i] == 1'b1 && cur[i] == 1'b0;
        3'd5: h = pv && prv[i] != cur[i];
        3'd6: h = pv && prv[i] == cur[i];
        default: h = 0;
      endcase
      if (!h) ok = 0;
    end
    case (op)
      3'd0: return ok;
      3'd1: return !ok;
      3'd2: return cur > k;
      3'd3: return cur < k;
      3'd4: return cur >= k;
      3'd5: return cur <= k;
      default: return 0;
    endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // driver: one sample per call, expectation pushed to the scoreboard
  task automatic drive(input logic [W-1:0] p, input bit ld, input logic [2:0] op,
                       input logic [CW-1:0] cd, input string tag);
    @(negedge clk);
    probe_i = p; cfg_load_i = ld; cfg_op_i = op; cfg_code_i = cd;
    if (rst_n) begin
      q.push_back('{model(p, m_prev, m_pv, m_op, m_cd), tag});
      m_prev = p;
      m_pv = 1;
    end
    if (ld) begin
      m_op = op;
      m_cd = cd;
    end
  endtask

  // idle config inputs are junk while load is low (R2 hold)
  task automatic step(input logic [W-1:0] p, input string tag);
    drive(p, 1'b0, 3'd0, mk("XXXXXXXX"), tag);
  endtask

  task automatic load(input logic [2:0] op, input string pat, input logic [W-1:0] p,
                      input string tag);
    drive(p, 1'b1, op, mk(pat), tag);
  endtask

  task automatic enter_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cfg_load_i = 1'b0;
    m_pv = 0;
    m_prev = '0;
    #1;
    checks++;
    if (match_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: match_o=%0b during reset expected 0", match_o);
    end
  endtask

  task automatic leave_reset(input logic [W-1:0] p, input string tag);
    @(negedge clk);
    rst_n = 1'b1;
    probe_i = p; cfg_load_i = 1'b0;
    q.push_back('{model(p, m_prev, m_pv, m_op, m_cd), tag});
    m_prev = p;
    m_pv = 1;
  endtask

  // monitor: compares one result after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (match_o !== it.exp) begin
          errors++;
          $display("FAIL %s: match_o=%0b expected %0b", it.tag, match_o, it.exp);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b1; probe_i = '0; cfg_load_i = 1'b0; cfg_op_i = '0; cfg_code_i = '0;
    #1 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    enter_reset();                                   // R1
    // R9: configure rising edge on bit 0 while reset is held
    drive(8'h00, 1'b1, 3'd0, mk("XXXXXXXR"), "R9");
    @(negedge clk);
    #1;
    checks++;
    if (match_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: match_o=%0b in reset expected 0", match_o);
    end
    leave_reset(8'h01, "R6");                        // first sample: no edge
    step(8'h00, "R5");
    step(8'h01, "R5 R9");                            // rise seen: config kept
    step(8'h01, "R10");

    // R3 ternary level pattern
    load(3'd0, "1X0XX101", 8'h00, "R2");
    step(8'b1000_0101, "R3");
    step(8'b1101_1101, "R3");
    step(8'b1010_0101, "R3");
    step(8'b1100_0100, "R3");
    step(8'b1111_1101, "R3");
    // R4 inverse
    load(3'd1, "1X0XX101", 8'b1000_0101, "R2");
    step(8'b1000_0101, "R4");
    step(8'b1010_0101, "R4");

    // R5 edge codes: bit3 either, bit2 still, bit1 fall, bit0 rise
    load(3'd0, "XXXXBNFR", 8'b0000_0010, "R2");
    step(8'b0000_1001, "R5");
    step(8'b0000_0011, "R5");
    step(8'b0000_1001, "R5");
    step(8'b0000_1001, "R5");
    step(8'b0000_0110, "R5");
    step(8'b0000_1101, "R5");
    load(3'd1, "XXXXBNFR", 8'b0000_0010, "R4");
    step(8'b0000_1001, "R4");
    step(8'b0000_1001, "R4");

    // R7 magnitude: operand 0x20 (X and R codes read as 0)
    load(3'd2, "0010X0R0", 8'h00, "R2");
    step(8'h21, "R7");
    step(8'h20, "R7");
    step(8'hFF, "R7");
    load(3'd3, "0010X0R0", 8'h1F, "R7");
    step(8'h1F, "R7");
    step(8'h20, "R7");
    load(3'd4, "0010X0R0", 8'h20, "R7");
    step(8'h20, "R7");
    step(8'h1F, "R7");
    load(3'd5, "0010X0R0", 8'h20, "R7");
    step(8'h20, "R7");
    step(8'h21, "R7");
    step(8'h00, "R7");

    // R8 disabled operators and never-code
    load(3'd6, "XXXXXXXX", 8'h55, "R8");
    step(8'h55, "R8");
    load(3'd7, "XXXXXXXX", 8'hAA, "R8");
    step(8'hAA, "R8");
    load(3'd0, "XXXX?XXX", 8'h00, "R2");
    step(8'h00, "R8");
    step(8'hFF, "R8");
    load(3'd1, "XXXX?XXX", 8'h00, "R8");
    step(8'h00, "R8");

    // R2 same-edge write: sample at the write edge uses old (off) setting
    load(3'd6, "XXXXXXXX", 8'h00, "R2");
    load(3'd0, "XXXXXXXX", 8'h3C, "R2");
    step(8'h3C, "R2");
    step(8'hC3, "R2 R10");

    // R6 again: still code across a reset release
    enter_reset();
    drive(8'h00, 1'b1, 3'd0, mk("XXXXXXXN"), "R9");
    leave_reset(8'h00, "R6");
    step(8'h00, "R6");
    step(8'h01, "R5");

    while (q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule